// File: doc/BRIEF.md
# Local-Bus DMA Slave Controller

This block is the slave side of a bridge's local bus, in front of two banks of external FIFOs. The bridge asks for the bus with a hold request. The controller grants it with a hold acknowledge. It then serves one access per address strobe. A read access becomes a DMA burst that drains one FIFO bank. A write access becomes a single-cycle write.

During a DMA read the controller drives the active-low ready line. It also drives the active-low read enable of the bank chosen by two address lines, so the chosen bank puts its data on the 32-bit local data bus. The burst-last input is active low. The burst ends on the clock edge where burst-last is sampled low. Ready and the bank enable are removed on that edge, so they drop one clock after the final transfer is flagged.

A completion state follows each access. From there the bridge either drops its hold request, which sends the controller back to idle, or starts another access without giving up the bus. Every output comes straight from a flip-flop.

Top module: `lbus_dma_ctrl`

## Requirements
- R1: While reset is low, and after it is released, holdAck is 0, readyN is 1 and bankRenN is all ones.
- R2: In idle, holdReq high makes holdAck 1 after the next edge. With holdReq low the controller stays idle and ignores adsN: holdAck stays 0 and readyN stays 1.
- R3: With the bus held, adsN low and wrNrd low (read) start a DMA read; readyN goes low after that edge. adsN low and wrNrd high (write) start a single write; readyN goes low and no bank enable is driven.
- R4: During a DMA read with blastN high, readyN and the selected bank enable stay low on every cycle.
- R5: During a DMA read, the edge that samples blastN low returns readyN and the bank enable to 1. This is the edge one clock after the last transfer is flagged.
- R6: The bank is latched from addrSel on the edge that starts a DMA read. addrSel is one-hot: the value with only bit k set selects bank k and drives bankRenN[k] low. With BANKS=2, 2'b10 drives bankRenN=2'b01 and 2'b01 drives 2'b10. A value that is not one-hot (2'b00, 2'b11) enables no bank, but readyN is still driven low.
- R7: A single write holds readyN low while blastN is high. The edge that samples blastN low ends the write; readyN returns to 1 and holdAck stays 1.
- R8: In completion, holdReq low returns to idle, and holdAck drops after that edge. holdReq high with blastN low returns to bus-hold, ready for a new access. holdReq high with blastN high stays in completion, and adsN is ignored there.
- R9: In bus-hold, holdReq low returns the controller to idle, and holdAck drops after that edge.
- R10: At most one bank enable is low at any time, and a bank enable is low only while readyN is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| holdReq | input | 1 | Bridge request for the local bus |
| adsN | input | 1 | Address strobe, active low |
| wrNrd | input | 1 | Access direction: 1 write, 0 read |
| blastN | input | 1 | Burst-last, active low |
| addrSel | input | BANKS | Bank-select address lines, one-hot |
| holdAck | output | 1 | Bus grant to the bridge |
| readyN | output | 1 | Transfer ready, active low |
| bankRenN | output | BANKS | Per-bank FIFO read enable, active low |

## Verification
The assertions assume the bridge follows the local-bus handshake. It raises the address strobe only while the bus is held. It keeps holdReq high for the length of an access. It marks the end of every access with blastN. They also assume addrSel is stable on the edge that samples the address strobe. The stimulus changes inputs only on falling clock edges. It opens each access only after holdAck is seen, and holds addrSel steady around the strobe edge. Strobes given in idle or in completion are there on purpose, to show that they are ignored.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HOLD  = 3'd1,
    ST_DMARD = 3'd2,
    ST_SWR   = 3'd3,
    ST_DONE  = 3'd4
  } busState_e;

  // strobes from control to datapath, describing the state being entered
  typedef struct packed {
    logic busOwn;   // controller owns the local bus
    logic dmaRd;    // burst read active
    logic sglWr;    // single write active
    logic capSel;   // latch the bank select this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/lbus_ctrl.sv
module lbus_ctrl
  import lbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        holdReq,
  input  logic        adsN,
  input  logic        wrNrd,
  input  logic        blastN,
  output ctrlStrobe_t strobe
);

  busState_e stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (holdReq) stateNext = ST_HOLD;
      ST_HOLD: begin
        if (!holdReq)            stateNext = ST_IDLE;
        else if (!adsN && !wrNrd) stateNext = ST_DMARD;
        else if (!adsN && wrNrd)  stateNext = ST_SWR;
      end
      ST_DMARD: if (!blastN) stateNext = ST_DONE;
      ST_SWR:   if (!blastN) stateNext = ST_DONE;
      ST_DONE: begin
        if (!holdReq)     stateNext = ST_IDLE;
        else if (!blastN) stateNext = ST_HOLD;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobe.busOwn = (stateNext != ST_IDLE);
    strobe.dmaRd  = (stateNext == ST_DMARD);
    strobe.sglWr  = (stateNext == ST_SWR);
    strobe.capSel = (stateQ == ST_HOLD) && (stateNext == ST_DMARD);
  end

  p_idle_to_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && holdReq) |=> (stateQ == ST_HOLD));

  p_idle_stay_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && !holdReq) |=> (stateQ == ST_IDLE));

  p_burst_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DMARD && blastN) |=> (stateQ == ST_DMARD));

  p_burst_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DMARD && !blastN) |=> (stateQ == ST_DONE));

  p_write_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SWR && blastN) |=> (stateQ == ST_SWR));

  p_done_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DONE && !holdReq) |=> (stateQ == ST_IDLE));

  p_hold_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_HOLD && !holdReq) |=> (stateQ == ST_IDLE));

endmodule

// File: rtl/lbus_dpath.sv
module lbus_dpath
  import lbus_pkg::*;
#(
  parameter int BANKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [BANKS-1:0] addrSel,
  output logic             holdAck,
  output logic             readyN,
  output logic [BANKS-1:0] bankRenN
);

  logic [BANKS-1:0] selQ, selDecoded, selNext;

  assign selDecoded = $onehot(addrSel) ? addrSel : '0;
  assign selNext    = strobe.capSel ? selDecoded : selQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ    <= '0;
      holdAck <= 1'b0;
      readyN  <= 1'b1;
    end else begin
      selQ    <= selNext;
      holdAck <= strobe.busOwn;
      readyN  <= !(strobe.dmaRd || strobe.sglWr);
    end
  end

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bankRenN[k] <= 1'b1;
      else       bankRenN[k] <= !(strobe.dmaRd && selNext[k]);
    end
  end

  p_one_bank_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~bankRenN));

  p_ren_with_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(&bankRenN) |-> !readyN);

  p_bank_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!(&bankRenN) && !(&$past(bankRenN))) |-> $stable(bankRenN));

  p_ready_owns_bus_r3: assert property (@(posedge clk) disable iff (!rstN)
    !readyN |-> holdAck);

endmodule

// File: rtl/lbus_dma_ctrl.sv
module lbus_dma_ctrl
  import lbus_pkg::*;
#(
  parameter int BANKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdReq,
  input  logic             adsN,
  input  logic             wrNrd,
  input  logic             blastN,
  input  logic [BANKS-1:0] addrSel,
  output logic             holdAck,
  output logic             readyN,
  output logic [BANKS-1:0] bankRenN
);

  ctrlStrobe_t strobe;

  lbus_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .holdReq (holdReq),
    .adsN    (adsN),
    .wrNrd   (wrNrd),
    .blastN  (blastN),
    .strobe  (strobe)
  );

  lbus_dpath #(.BANKS(BANKS)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addrSel  (addrSel),
    .holdAck  (holdAck),
    .readyN   (readyN),
    .bankRenN (bankRenN)
  );

endmodule

// File: tb/lbus_dma_ctrl_test.sv
module lbus_dma_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       holdReq = 1'b0, adsN = 1'b1, wrNrd = 1'b0, blastN = 1'b1;
  logic [1:0] addrSel = 2'b00;
  logic       holdAck, readyN;
  logic [1:0] bankRenN;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [3:0] outs;   // {holdAck, readyN, bankRenN}
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lbus_dma_ctrl #(.BANKS(2)) uut (
    .clk(clk), .rstN(rstN), .holdReq(holdReq), .adsN(adsN), .wrNrd(wrNrd),
    .blastN(blastN), .addrSel(addrSel), .holdAck(holdAck), .readyN(readyN),
    .bankRenN(bankRenN)
  );

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {holdAck, readyN, bankRenN};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act ack/rdyN/ren=%b expected %b", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs at the falling edge; expect outputs after the next rising edge
  task automatic step(input logic hr, input logic ads, input logic wr, input logic bl,
                      input logic [1:0] ad, input logic [3:0] exp, input string tag);
    expItem_t it;
    @(negedge clk);
    holdReq = hr; adsN = ads; wrNrd = wr; blastN = bl; addrSel = ad;
    it.outs = exp; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.outs, it.tag);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: act still running, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(4'b0111, "R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    check(4'b0111, "R1 after reset");

    // hr ads wr bl addr  expected {ack,rdyN,ren}
    step(0, 0, 0, 1, 2'b10, 4'b0111, "R2 strobe ignored in idle");
    step(1, 1, 0, 1, 2'b00, 4'b1111, "R2 hold granted");
    step(1, 0, 0, 1, 2'b10, 4'b1001, "R3 R6 read to bank1");
    step(1, 1, 0, 1, 2'b00, 4'b1001, "R4 burst continues");
    step(1, 0, 1, 1, 2'b01, 4'b1001, "R4 burst continues, bank held");
    step(1, 1, 0, 1, 2'b00, 4'b1001, "R4 burst continues");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R5 enable removed after blast");
    step(1, 0, 0, 1, 2'b10, 4'b1111, "R8 completion holds, strobe ignored");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R8 completion back to hold");
    step(1, 0, 0, 1, 2'b01, 4'b1010, "R6 read to bank0");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R5 bank0 enable removed");
    step(0, 1, 0, 1, 2'b00, 4'b0111, "R8 completion release to idle");
    step(1, 1, 0, 1, 2'b00, 4'b1111, "R2 hold granted again");
    step(1, 0, 1, 1, 2'b10, 4'b1011, "R3 R7 single write, no bank");
    step(1, 1, 1, 1, 2'b00, 4'b1011, "R7 write holds ready");
    step(1, 1, 1, 0, 2'b00, 4'b1111, "R7 write ends on blast");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R8 completion back to hold");
    step(1, 0, 0, 1, 2'b11, 4'b1011, "R6 invalid select, no bank");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R5 invalid-select burst ends");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R8 completion back to hold");
    step(1, 0, 0, 1, 2'b00, 4'b1011, "R6 zero select, no bank");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R5 zero-select burst ends");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R8 completion back to hold");
    step(0, 1, 0, 1, 2'b00, 4'b0111, "R9 hold dropped in bus-hold");
    step(1, 1, 0, 1, 2'b00, 4'b1111, "R2 hold granted");
    step(1, 0, 0, 0, 2'b10, 4'b1001, "R10 one-beat burst, bank1");
    step(1, 1, 0, 0, 2'b00, 4'b1111, "R5 one-beat burst ends");
    step(0, 1, 0, 1, 2'b00, 4'b0111, "R8 release to idle");
    step(0, 1, 0, 1, 2'b00, 4'b0111, "R2 idle stays idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule